// File: doc/BRIEF.md
# Field-Programmable AND-OR Logic Array

This block is a programmable two-level logic array. It has `N_IN` primary inputs, `N_TERM` shared product-term lines and `N_OUT` outputs. Every product-term line can connect to the true form or the inverted form of any input, and it forms the AND of the literals it connects to. Every output can connect to any subset of the product-term lines, and it forms the OR of the terms it connects to. `N_TERM` is meant to be far smaller than `2**N_IN`, so the array cannot form every minterm. Several outputs can share one term, which keeps the number of term lines low.

Both planes live in configuration registers. The registers are loaded through a plain address/data write port with a single strobe. This port has no back-pressure: a write is taken on every rising clock edge where `cfg_we` is high. Evaluation from `pla_in` to `pla_out` is purely combinational and does not wait for a clock edge. A synchronous reset clears every connection, so all outputs read 0 until the array is programmed.

Top module: `pla_array`

## Requirements
- R1: AND-row data bit `i` (for `i` below `N_IN`) connects the true literal of `pla_in[i]` to the term. Data bit `N_IN+i` connects the inverted literal of `pla_in[i]`. The term is 1 only when every connected literal is 1.
- R2: A product term with no connected literals reads as constant 1.
- R3: A product term that connects both the true and the inverted literal of the same input reads as constant 0.
- R4: Output `o` is the OR of the terms selected by OR-row bit `t` (term `t`). An output with no selected terms reads as constant 0.
- R5: One product term can drive several outputs at the same time.
- R6: A write with `cfg_we` high loads a row on the rising edge. Addresses `0..N_TERM-1` load the AND row of that term from `cfg_wdata[2*N_IN-1:0]`. Addresses `N_TERM..N_TERM+N_OUT-1` load the OR row of output `addr-N_TERM` from `cfg_wdata[N_TERM-1:0]`. The new row takes effect right after that edge.
- R7: A write to an address at or above `N_TERM+N_OUT` changes no configuration and has no effect on any output.
- R8: While `rst` is high at a rising edge, every connection bit is cleared, so every output reads 0 for every input.
- R9: `pla_out` follows a change on `pla_in` with no clock edge in between.
- R10: With 4 inputs (`pla_in[3]`=A down to `pla_in[0]`=D), 6 terms and 3 outputs, the array can be programmed so that `pla_out[0]` = C'D'+B'D'+AB'+ABC, `pla_out[1]` = C'D'+B'D'+ABC+A'BC and `pla_out[2]` = B'D'+CD+A'BC for all 16 input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous reset, active high, clears all connections |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW = $clog2(N_TERM+N_OUT) | Row select: AND rows first, then OR rows |
| cfg_wdata | input | DW = max(2*N_IN, N_TERM) | Row contents |
| pla_in | input | N_IN | Primary inputs |
| pla_out | output | N_OUT | Array outputs |

## Verification
The shared-term example is loaded and all 16 input values are swept. This separates a correct array from one that drops a shared term or mixes up the true and inverted literals. Single-literal rows, in true form and then in inverted form, show the literal polarity on its own. Rows with no connections and rows with conflicting connections show the constant-1 term and the constant-0 output. Writes above the top valid address, a reset after programming, and input changes with no clock edge show that configuration is kept apart from evaluation.

// File: rtl/pla_pkg.sv
package pla_pkg;
  function automatic int pla_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pla_cfg_regs.sv
module pla_cfg_regs #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 we,
  input  logic [AW-1:0]                        addr,
  input  logic [DW-1:0]                        wdata,
  output logic [N_TERM-1:0][2*N_IN-1:0]        and_cfg,
  output logic [N_OUT-1:0][N_TERM-1:0]         or_cfg
);
  localparam int AND_W = 2 * N_IN;

  // one register row per product term
  for (genvar t = 0; t < N_TERM; t++) begin : g_and_row
    always_ff @(posedge clk) begin
      if (rst)
        and_cfg[t] <= '0;
      else if (we && addr == AW'(t))
        and_cfg[t] <= wdata[AND_W-1:0];
    end
  end

  // one register row per output, placed after the term rows
  for (genvar o = 0; o < N_OUT; o++) begin : g_or_row
    always_ff @(posedge clk) begin
      if (rst)
        or_cfg[o] <= '0;
      else if (we && addr == AW'(N_TERM + o))
        or_cfg[o] <= wdata[N_TERM-1:0];
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6
) (
  input  logic [N_IN-1:0]                 x,
  input  logic [N_TERM-1:0][2*N_IN-1:0]   and_cfg,
  output logic [N_TERM-1:0]               term
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] use_true, use_comp, lit_ok;
    assign use_true = and_cfg[t][N_IN-1:0];
    assign use_comp = and_cfg[t][2*N_IN-1:N_IN];
    // an unconnected literal never pulls the line low
    assign lit_ok  = (~use_true | x) & (~use_comp | ~x);
    assign term[t] = &lit_ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3
) (
  input  logic [N_TERM-1:0]               term,
  input  logic [N_OUT-1:0][N_TERM-1:0]    or_cfg,
  output logic [N_OUT-1:0]                y
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign y[o] = |(or_cfg[o] & term);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 6,
  parameter int N_OUT  = 3,
  localparam int AND_W = 2 * N_IN,
  localparam int DW    = pla_max(AND_W, N_TERM),
  localparam int AW    = $clog2(N_TERM + N_OUT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [N_IN-1:0]  pla_in,
  output logic [N_OUT-1:0] pla_out
);
  logic [N_TERM-1:0][AND_W-1:0]  and_cfg;
  logic [N_OUT-1:0][N_TERM-1:0]  or_cfg;
  logic [N_TERM-1:0]             term;

  pla_cfg_regs #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW), .DW(DW)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .and_cfg(and_cfg), .or_cfg(or_cfg)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .x(pla_in), .and_cfg(and_cfg), .term(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term(term), .or_cfg(or_cfg), .y(pla_out)
  );

  // ---------------- assertions ----------------
  for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
    AST_AND_ROW_LOAD: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == AW'(t)) |=> and_cfg[t] == $past(cfg_wdata[AND_W-1:0])); // R6
    AST_EMPTY_TERM_HIGH: assert property (@(posedge clk) disable iff (rst)
      (and_cfg[t] == '0) |-> term[t]); // R2
    AST_CONFLICT_TERM_LOW: assert property (@(posedge clk) disable iff (rst)
      (|(and_cfg[t][N_IN-1:0] & and_cfg[t][AND_W-1:N_IN])) |-> !term[t]); // R3
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
    AST_OR_ROW_LOAD: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == AW'(N_TERM + o)) |=> or_cfg[o] == $past(cfg_wdata[N_TERM-1:0])); // R6
    AST_OUT_NEEDS_TERM: assert property (@(posedge clk) disable iff (rst)
      pla_out[o] |-> (|(or_cfg[o] & term))); // R4
  end

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr >= AW'(N_TERM + N_OUT)) |=> $stable({and_cfg, or_cfg})); // R7
  AST_RESET_OUT_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (pla_out == '0)); // R8
endmodule

// File: tb/test_pla_array.sv
module test_pla_array;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] pla_in = '0;
  logic [2:0] pla_out;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pla_array i_pla_array (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pla_in(pla_in), .pla_out(pla_out)
  );

  function automatic logic [2:0] ref_eq(input logic [3:0] v);
    logic a, b, c, d;
    {a, b, c, d} = v;
    ref_eq[0] = (!c && !d) || (!b && !d) || (a && !b) || (a && b && c);
    ref_eq[1] = (!c && !d) || (!b && !d) || (a && b && c) || (!a && b && c);
    ref_eq[2] = (!b && !d) || (c && d) || (!a && b && c);
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s in=%b act=%b exp=%b", req, pla_in, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic load_example();
    wr(4'd0, 8'b0011_0000); // C'D'
    wr(4'd1, 8'b0101_0000); // B'D'
    wr(4'd2, 8'b0100_1000); // AB'
    wr(4'd3, 8'b0000_1110); // ABC
    wr(4'd4, 8'b1000_0110); // A'BC
    wr(4'd5, 8'b0000_0011); // CD
    wr(4'd6, 8'b0000_1111); // X
    wr(4'd7, 8'b0001_1011); // Y
    wr(4'd8, 8'b0011_0010); // Z
  endtask

  task automatic sweep(input string req, input bit use_ref, input logic [2:0] fixed);
    for (int v = 0; v < 16; v++) begin
      pla_in = 4'(v); #1;
      chk(req, pla_out, use_ref ? ref_eq(4'(v)) : fixed);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    sweep("R8 after reset", 1'b0, 3'b000);
  endtask

  task automatic t_example();
    do_reset();
    load_example();
    sweep("R10 shared-term example", 1'b1, 3'b000);
  endtask

  task automatic t_empty_term();
    do_reset();
    wr(4'd6, 8'b0000_0001); // output 0 takes term 0, term 0 unconnected
    sweep("R2/R4 empty term high, empty outputs low", 1'b0, 3'b001);
  endtask

  task automatic t_literals();
    do_reset();
    wr(4'd0, 8'b0000_1000); // true A
    wr(4'd6, 8'b0000_0001);
    for (int v = 0; v < 16; v++) begin
      pla_in = 4'(v); #1;
      chk("R1 true literal", pla_out, {2'b00, pla_in[3]});
    end
    wr(4'd0, 8'b0000_0100 << 4); // inverted B
    for (int v = 0; v < 16; v++) begin
      pla_in = 4'(v); #1;
      chk("R1 inverted literal", pla_out, {2'b00, ~pla_in[2]});
    end
  endtask

  task automatic t_conflict();
    do_reset();
    wr(4'd0, 8'b0010_0010); // C and C'
    wr(4'd6, 8'b0000_0001);
    sweep("R3 conflicting literals", 1'b0, 3'b000);
  endtask

  task automatic t_share();
    do_reset();
    wr(4'd3, 8'b0000_0001); // term 3 = D
    wr(4'd6, 8'b0000_1000);
    wr(4'd7, 8'b0000_1000);
    wr(4'd8, 8'b0000_1000);
    for (int v = 0; v < 16; v++) begin
      pla_in = 4'(v); #1;
      chk("R5 one term on all outputs", pla_out, {3{pla_in[0]}});
    end
  endtask

  task automatic t_out_of_range();
    do_reset();
    load_example();
    for (int a = 9; a < 16; a++) wr(4'(a), 8'hFF);
    sweep("R7 out-of-range writes ignored", 1'b1, 3'b000);
    wr(4'd8, 8'b0000_0000);
    for (int v = 0; v < 16; v++) begin
      pla_in = 4'(v); #1;
      chk("R6 OR row rewrite", pla_out, {1'b0, ref_eq(4'(v))[1:0]});
    end
  endtask

  task automatic t_comb_and_rereset();
    do_reset();
    load_example();
    @(negedge clk);
    pla_in = 4'b0000; #0.5;
    chk("R9 no clock needed", pla_out, ref_eq(4'b0000));
    pla_in = 4'b0011; #0.5;
    chk("R9 no clock needed", pla_out, ref_eq(4'b0011));
    pla_in = 4'b0110; #0.5;
    chk("R9 no clock needed", pla_out, ref_eq(4'b0110));
    do_reset();
    sweep("R8 reset clears programmed array", 1'b0, 3'b000);
  endtask

  initial begin
    t_reset_state();
    t_example();
    t_empty_term();
    t_literals();
    t_conflict();
    t_share();
    t_out_of_range();
    t_comb_and_rereset();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule